// File: doc/BRIEF.md
# Dual-Half LCD Scan Timing Generator

This block produces the refresh timing for a dot-matrix liquid crystal panel whose rows are split into an upper and a lower half, each driven by its own serial data line. The panel geometry is set by several inputs: the horizontal pitch Hp in dots, the number of items per line HN, the number of scan lines per half NX, the vertical character pitch Vp, and the memory address of the top-left item. From these settings it steps through every line of a frame. For each item on a line it requests one byte for the upper half and one byte for the lower half from display memory. It then sends the top Hp bits of both bytes out at the same time, most significant bit first, together with a shift clock, a line latch pulse, a frame marker and an AC inversion signal.

There are two modes. In graphic mode the full 16-bit address goes to memory and each scan line reads a fresh run of HN bytes. In character mode one row of items is reread for Vp consecutive scan lines. The four top address bits then carry the glyph line number, which is also available on its own port for an external character generator. Memory answers over a plain request/valid port. A byte that has not arrived by the time it must be shifted is replaced by blanks, and a sticky underrun flag is raised.

Top module: `lcd_scan_gen`

## Requirements
- R1: While reset is held, cl2, ac_m, d_up, d_lo, underrun and line_no are 0, and flm is 1.
- R2: Each line period lasts 2 + 2·HN·Hp cycles. Its first cycle is a one-cycle cl1 pulse and its second cycle is idle. Every bit then occupies two cycles, with cl2 low in the first and high in the second.
- R3: For item k of a line, d_up and d_lo carry bits 7 down to 8−Hp of the upper and lower bytes fetched for that item, most significant bit first, and each bit is held for its two-cycle slot. Both outputs are 0 during the two lead cycles.
- R4: The upper fetch address for item k on a line in row r is start + r·HN + k, modulo 2^16. In graphic mode r is the scan line index within the frame.
- R5: In character mode a glyph line counter runs from 0 to Vp−1 and appears on line_no and on address bits 15..12 of both fetch addresses. The row r advances by one after Vp scan lines. In graphic mode line_no is 0.
- R6: The lower fetch address is the upper one plus HN·NX in graphic mode, or plus HN·floor(NX/Vp) in character mode, before the glyph nibble is applied.
- R7: A frame is NX line periods, and flm is 1 for the whole first line period of each frame.
- R8: ac_m is 0 after reset and inverts at the start of every new frame.
- R9: With disp_on at 0, d_up and d_lo stay 0 while every other output keeps its normal timing.
- R10: mem_req is a one-cycle pulse. It fires in the cl1 cycle for item 0, and in the first cycle of item k for item k+1 when k < HN−1. A response is accepted any time up to the cycle in which the byte is loaded, including that cycle itself.
- R11: If no response has arrived when a byte is due to be loaded, that byte is shifted out as zeros and underrun becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_on | input | 1 | 1 enables serial data, 0 blanks it |
| char_mode | input | 1 | 1 selects character mode, 0 graphic mode |
| hp_m1 | input | 3 | Horizontal pitch minus one (Hp = 1..8) |
| hn_m1 | input | 7 | Items per line minus one |
| nx_m1 | input | 7 | Scan lines per half minus one |
| vp_m1 | input | 4 | Vertical character pitch minus one |
| start_addr | input | 16 | Memory address of the top-left item |
| mem_req | output | 1 | Fetch request, one cycle |
| mem_addr_up | output | 16 | Fetch address for the upper half |
| mem_addr_lo | output | 16 | Fetch address for the lower half |
| mem_valid | input | 1 | Both fetched bytes are present this cycle |
| mem_data_up | input | 8 | Upper-half byte |
| mem_data_lo | input | 8 | Lower-half byte |
| cl2 | output | 1 | Bit shift clock |
| cl1 | output | 1 | Line latch pulse |
| flm | output | 1 | Frame marker |
| ac_m | output | 1 | AC inversion signal |
| d_up | output | 1 | Serial data, upper half |
| d_lo | output | 1 | Serial data, lower half |
| line_no | output | 4 | Glyph line counter |
| underrun | output | 1 | Sticky fetch underrun flag |

## Verification
The assertions check the following on every cycle:
- cl2 and mem_req are single-cycle pulses.
- A line end is always followed by a latch.
- flm rises only right after a line end.
- ac_m changes only at the start of line 0.
- The glyph counter never passes Vp−1.
- underrun never clears once set.

The bench's per-cycle sweeps over whole frames cover what the assertions cannot:
- the exact bit order and the Hp truncation;
- the address arithmetic, including the floor division for the lower half and 16-bit wraparound;
- blanking with the display off;
- zero fill after a missed fetch.

// File: rtl/lcds_pkg.sv
package lcds_pkg;

   // Cycle roles inside one line period.
   typedef enum logic [1:0] {
      SLOT_LATCH = 2'd0,
      SLOT_SETUP = 2'd1,
      SLOT_LOW   = 2'd2,
      SLOT_HIGH  = 2'd3
   } slot_e;

endpackage

// File: rtl/lcds_seq.sv
module lcds_seq
   import lcds_pkg::*;
#(
   parameter int HNW = 7,
   parameter int HPW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HPW-1:0] hp_m1,
   input  logic [HNW-1:0] hn_m1,
   output logic           cl1,
   output logic           cl2,
   output logic           active,
   output logic           mem_req,
   output logic [HNW-1:0] fidx,
   output logic           load_now,
   output logic           shift_now,
   output logic           line_end
);

   slot_e          slot_q;
   logic [HPW-1:0] bit_q;
   logic [HNW-1:0] item_q;
   logic           last_bit;
   logic           last_item;

   assign last_bit  = (bit_q == hp_m1);
   assign last_item = (item_q == hn_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= SLOT_LATCH;
         bit_q  <= '0;
         item_q <= '0;
      end else begin
         case (slot_q)
            SLOT_LATCH: slot_q <= SLOT_SETUP;
            SLOT_SETUP: begin
               slot_q <= SLOT_LOW;
               bit_q  <= '0;
               item_q <= '0;
            end
            SLOT_LOW:   slot_q <= SLOT_HIGH;
            default: begin
               if (last_bit) begin
                  bit_q <= '0;
                  if (last_item) begin
                     slot_q <= SLOT_LATCH;
                  end else begin
                     item_q <= item_q + HNW'(1);
                     slot_q <= SLOT_LOW;
                  end
               end else begin
                  bit_q  <= bit_q + HPW'(1);
                  slot_q <= SLOT_LOW;
               end
            end
         endcase
      end
   end

   assign cl1       = (slot_q == SLOT_LATCH);
   assign cl2       = (slot_q == SLOT_HIGH);
   assign active    = (slot_q == SLOT_LOW) || (slot_q == SLOT_HIGH);
   assign line_end  = cl2 && last_bit && last_item;
   assign load_now  = (slot_q == SLOT_SETUP) || (cl2 && last_bit && !last_item);
   assign shift_now = cl2 && !(last_bit && !last_item);
   assign mem_req   = cl1 || ((slot_q == SLOT_LOW) && (bit_q == '0) && !last_item);
   assign fidx      = cl1 ? '0 : item_q + HNW'(1);

   assert_cl2_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cl2 |=> !cl2);
   assert_latch_after_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> cl1);
   assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

endmodule

// File: rtl/lcds_raster.sv
module lcds_raster #(
   parameter int AW  = 16,
   parameter int HNW = 7,
   parameter int NXW = 7,
   parameter int VPW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_end,
   input  logic           char_mode,
   input  logic [HNW-1:0] hn_m1,
   input  logic [NXW-1:0] nx_m1,
   input  logic [VPW-1:0] vp_m1,
   input  logic [AW-1:0]  start_addr,
   input  logic [HNW-1:0] fidx,
   output logic [AW-1:0]  addr_up,
   output logic [AW-1:0]  addr_lo,
   output logic [VPW-1:0] line_no,
   output logic           flm,
   output logic           ac
);

   localparam int HW = HNW + 1;
   localparam int NW = NXW + 1;
   localparam int VW = VPW + 1;

   logic [NXW-1:0] line_q;
   logic [NXW-1:0] row_q;
   logic [VPW-1:0] glyph_q;
   logic           ac_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         row_q   <= '0;
         glyph_q <= '0;
         ac_q    <= 1'b0;
      end else if (line_end) begin
         if (line_q == nx_m1) begin
            line_q  <= '0;
            row_q   <= '0;
            glyph_q <= '0;
            ac_q    <= !ac_q;
         end else begin
            line_q <= line_q + NXW'(1);
            if (char_mode && (glyph_q != vp_m1)) begin
               glyph_q <= glyph_q + VPW'(1);
            end else begin
               glyph_q <= '0;
               row_q   <= row_q + NXW'(1);
            end
         end
      end
   end

   logic [HW-1:0] hn_cnt;
   logic [NW-1:0] nx_cnt;
   logic [VW-1:0] vp_cnt;
   logic [NW-1:0] half_rows;
   logic [AW-1:0] base_up;
   logic [AW-1:0] base_lo;

   assign hn_cnt    = HW'(hn_m1) + HW'(1);
   assign nx_cnt    = NW'(nx_m1) + NW'(1);
   assign vp_cnt    = VW'(vp_m1) + VW'(1);
   assign half_rows = char_mode ? NW'(nx_cnt / NW'(vp_cnt)) : nx_cnt;

   assign base_up = start_addr + AW'(row_q) * AW'(hn_cnt) + AW'(fidx);
   assign base_lo = base_up + AW'(half_rows) * AW'(hn_cnt);

   assign addr_up = char_mode ? {glyph_q, base_up[AW-VPW-1:0]} : base_up;
   assign addr_lo = char_mode ? {glyph_q, base_lo[AW-VPW-1:0]} : base_lo;
   assign line_no = glyph_q;
   assign flm     = (line_q == '0);
   assign ac      = ac_q;

   assert_glyph_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      char_mode |-> (glyph_q <= vp_m1));
   assert_flm_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flm) |-> $past(line_end));
   assert_ac_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ac_q) |-> ((line_q == '0) && $past(line_end)));

endmodule

// File: rtl/lcds_ser.sv
module lcds_ser #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_now,
   input  logic          shift_now,
   input  logic          show,
   input  logic          mem_valid,
   input  logic [DW-1:0] mem_data,
   output logic          sd,
   output logic          underrun
);

   logic [DW-1:0] hold_q;
   logic [DW-1:0] sh_q;
   logic          full_q;
   logic          under_q;
   logic          have;
   logic [DW-1:0] src;

   assign have = mem_valid || full_q;
   assign src  = mem_valid ? mem_data : hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         sh_q    <= '0;
         full_q  <= 1'b0;
         under_q <= 1'b0;
      end else if (load_now) begin
         sh_q   <= have ? src : '0;
         full_q <= 1'b0;
         if (!have) under_q <= 1'b1;
      end else begin
         if (mem_valid) begin
            hold_q <= mem_data;
            full_q <= 1'b1;
         end
         if (shift_now) sh_q <= {sh_q[DW-2:0], 1'b0};
      end
   end

   assign sd       = show && sh_q[DW-1];
   assign underrun = under_q;

   assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      under_q |=> under_q);

endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen #(
   parameter int AW  = 16,
   parameter int DW  = 8,
   parameter int HPW = 3,
   parameter int HNW = 7,
   parameter int NXW = 7,
   parameter int VPW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           disp_on,
   input  logic           char_mode,
   input  logic [HPW-1:0] hp_m1,
   input  logic [HNW-1:0] hn_m1,
   input  logic [NXW-1:0] nx_m1,
   input  logic [VPW-1:0] vp_m1,
   input  logic [AW-1:0]  start_addr,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr_up,
   output logic [AW-1:0]  mem_addr_lo,
   input  logic           mem_valid,
   input  logic [DW-1:0]  mem_data_up,
   input  logic [DW-1:0]  mem_data_lo,
   output logic           cl2,
   output logic           cl1,
   output logic           flm,
   output logic           ac_m,
   output logic           d_up,
   output logic           d_lo,
   output logic [VPW-1:0] line_no,
   output logic           underrun
);

   localparam int HALVES = 2;

   if (DW != (1 << HPW)) begin : g_bad_pitch
      $error("byte width must equal the largest pitch");
   end
   if (AW <= VPW) begin : g_bad_addr
      $error("address too narrow for glyph line field");
   end

   logic           active;
   logic           load_now;
   logic           shift_now;
   logic           line_end;
   logic [HNW-1:0] fidx;

   lcds_seq #(.HNW(HNW), .HPW(HPW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hp_m1     (hp_m1),
      .hn_m1     (hn_m1),
      .cl1       (cl1),
      .cl2       (cl2),
      .active    (active),
      .mem_req   (mem_req),
      .fidx      (fidx),
      .load_now  (load_now),
      .shift_now (shift_now),
      .line_end  (line_end)
   );

   lcds_raster #(.AW(AW), .HNW(HNW), .NXW(NXW), .VPW(VPW)) u_raster (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_end   (line_end),
      .char_mode  (char_mode),
      .hn_m1      (hn_m1),
      .nx_m1      (nx_m1),
      .vp_m1      (vp_m1),
      .start_addr (start_addr),
      .fidx       (fidx),
      .addr_up    (mem_addr_up),
      .addr_lo    (mem_addr_lo),
      .line_no    (line_no),
      .flm        (flm),
      .ac         (ac_m)
   );

   logic [HALVES-1:0][DW-1:0] half_data;
   logic [HALVES-1:0]         half_sd;
   logic [HALVES-1:0]         half_under;

   assign half_data = {mem_data_lo, mem_data_up};

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      lcds_ser #(.DW(DW)) u_ser (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_now  (load_now),
         .shift_now (shift_now),
         .show      (disp_on && active),
         .mem_valid (mem_valid),
         .mem_data  (half_data[h]),
         .sd        (half_sd[h]),
         .underrun  (half_under[h])
      );
   end

   assign d_up     = half_sd[0];
   assign d_lo     = half_sd[1];
   assign underrun = |half_under;

endmodule

// File: tb/test_lcd_scan_gen.sv
module test_lcd_scan_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_on = 1'b0;
   logic        char_mode = 1'b0;
   logic [2:0]  hp_m1 = '0;
   logic [6:0]  hn_m1 = '0;
   logic [6:0]  nx_m1 = '0;
   logic [3:0]  vp_m1 = '0;
   logic [15:0] start_addr = '0;
   logic        mem_req;
   logic [15:0] mem_addr_up, mem_addr_lo;
   logic        mem_valid;
   logic [7:0]  mem_data_up, mem_data_lo;
   logic        cl2, cl1, flm, ac_m, d_up, d_lo, underrun;
   logic [3:0]  line_no;
   logic        stall = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = !clk;

   lcd_scan_gen i_lcd_scan_gen (
      .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .char_mode(char_mode),
      .hp_m1(hp_m1), .hn_m1(hn_m1), .nx_m1(nx_m1), .vp_m1(vp_m1),
      .start_addr(start_addr), .mem_req(mem_req), .mem_addr_up(mem_addr_up),
      .mem_addr_lo(mem_addr_lo), .mem_valid(mem_valid), .mem_data_up(mem_data_up),
      .mem_data_lo(mem_data_lo), .cl2(cl2), .cl1(cl1), .flm(flm), .ac_m(ac_m),
      .d_up(d_up), .d_lo(d_lo), .line_no(line_no), .underrun(underrun)
   );

   function automatic logic [7:0] mdata(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   // Memory model: answers one cycle after a request.
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_valid   <= 1'b0;
         mem_data_up <= '0;
         mem_data_lo <= '0;
      end else begin
         mem_valid   <= mem_req && !stall;
         mem_data_up <= mdata(mem_addr_up);
         mem_data_lo <= mdata(mem_addr_lo);
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(input bit lower, input bit ch, input int l,
         input int item, input int hn, input int nx, input int vp, input logic [15:0] st);
      int rows, row, g, a;
      logic [15:0] r;
      rows = ch ? nx / vp : nx;
      row  = ch ? l / vp : l;
      g    = ch ? l % vp : 0;
      a    = int'(st) + ((lower ? rows : 0) + row) * hn + item;
      r    = 16'(a);
      if (ch) r[15:12] = 4'(g);
      return r;
   endfunction

   task automatic run_cfg(input bit ch, input int hp, input int hn, input int nx,
         input int vp, input logic [15:0] st, input bit dsp, input bit stl, input int frames);
      int len;
      len = 2 + 2 * hn * hp;
      char_mode = ch; hp_m1 = 3'(hp - 1); hn_m1 = 7'(hn - 1);
      nx_m1 = 7'(nx - 1); vp_m1 = 4'(vp - 1); start_addr = st;
      disp_on = dsp; stall = stl; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 cl2 in reset", 32'(cl2), 0);
      chk("R1 ac_m in reset", 32'(ac_m), 0);
      chk("R1 flm in reset", 32'(flm), 1);
      chk("R1 data in reset", {30'd0, d_up, d_lo}, 0);
      chk("R1 underrun in reset", 32'(underrun), 0);
      chk("R1 line_no in reset", 32'(line_no), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int f = 0; f < frames; f++) begin
         for (int l = 0; l < nx; l++) begin
            for (int c = 0; c < len; c++) begin
               int j, slot, item, b, fi;
               bit exp_req, exp_du, exp_dl, exp_un;
               logic [7:0] bu, bl;
               j = c - 2; slot = (c >= 2) ? j / 2 : 0;
               item = slot / hp; b = slot % hp;
               chk("R2 cl1", 32'(cl1), 32'(c == 0));
               chk("R2 cl2", 32'(cl2), 32'(c >= 2 && (j % 2) == 1));
               chk("R7 flm", 32'(flm), 32'(l == 0));
               chk("R8 ac_m", 32'(ac_m), 32'(f % 2));
               chk("R5 line_no", 32'(line_no), ch ? 32'(l % vp) : 0);
               exp_req = (c == 0) || (c >= 2 && (j % (2 * hp)) == 0 && (j / (2 * hp)) < hn - 1);
               chk("R10 mem_req", 32'(mem_req), 32'(exp_req));
               if (exp_req) begin
                  fi = (c == 0) ? 0 : j / (2 * hp) + 1;
                  chk("R4 upper address", 32'(mem_addr_up),
                      32'(exp_addr(1'b0, ch, l, fi, hn, nx, vp, st)));
                  chk("R6 lower address", 32'(mem_addr_lo),
                      32'(exp_addr(1'b1, ch, l, fi, hn, nx, vp, st)));
               end
               bu = mdata(exp_addr(1'b0, ch, l, item, hn, nx, vp, st));
               bl = mdata(exp_addr(1'b1, ch, l, item, hn, nx, vp, st));
               exp_du = (c >= 2) && dsp && !stl && bu[7 - b];
               exp_dl = (c >= 2) && dsp && !stl && bl[7 - b];
               chk(dsp ? "R3 d_up" : "R9 d_up blanked", 32'(d_up), 32'(exp_du));
               chk(dsp ? "R3 d_lo" : "R9 d_lo blanked", 32'(d_lo), 32'(exp_dl));
               exp_un = stl && !(f == 0 && l == 0 && c < 2);
               chk("R11 underrun", 32'(underrun), 32'(exp_un));
               @(negedge clk);
               #1;
            end
         end
      end
   endtask

   initial begin
      // graphic, full pitch
      run_cfg(1'b0, 8, 2, 3, 1, 16'h1234, 1'b1, 1'b0, 2);
      // character mode, NX not a multiple of Vp, address wraps
      run_cfg(1'b1, 6, 4, 5, 2, 16'hFFF0, 1'b1, 1'b0, 2);
      // display off keeps timing
      run_cfg(1'b0, 7, 2, 2, 1, 16'h0100, 1'b0, 1'b0, 2);
      // memory never answers
      run_cfg(1'b1, 8, 2, 4, 4, 16'h0040, 1'b1, 1'b1, 2);
      // smallest geometry: one bit, one item, one line
      run_cfg(1'b0, 1, 1, 1, 1, 16'h0000, 1'b1, 1'b0, 3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule